// File: doc/BRIEF.md
# Sleep-Mode Clock Enable Controller

This block holds the one-byte power control register of a small microcontroller core and turns its mode bits into two clock enables. One enable gates the CPU core clock. The other runs the oscillator, which also feeds the timer, serial and interrupt logic. Software writes the whole byte over a special-function-register bus and can read it back. There is no single-bit access.

There are two sleep levels. In light sleep only the CPU clock is gated. In deep sleep the oscillator stops, and with it every clock. When both mode bits are set at once, deep sleep wins. An interrupt request (`irq_wake`) or a reset clears both mode bits and wakes the core. A wake leaves the other register bits as they are. The register also exports a baud-doubling flag for the serial port and two general-purpose flags.

The clock pin is the free-running source clock, taken ahead of any gating. This lets a wake request be seen even while the gated clocks are stopped.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `cpu_clk_en` and `osc_clk_en` are 1, `pwr_mode` is 0 (run), and `baud_double` and `gp_flag` are 0.
- R2: A write with `sfr_wr_en` high and `sfr_addr` equal to 0x87 stores the byte on the next clock edge. A write to any other address leaves the register unchanged. `sfr_rd_data` shows the register while `sfr_addr` is 0x87 and shows 0x00 otherwise.
- R3: Bits 6 to 4 always read 0, and writes to them are ignored.
- R4: With bit 0 (light sleep) set and bit 1 clear, `cpu_clk_en` is 0, `osc_clk_en` is 1 and `pwr_mode` is 1.
- R5: With bit 1 (deep sleep) set, `osc_clk_en` and `cpu_clk_en` are both 0 and `pwr_mode` is 2. This holds whatever the value of bit 0.
- R6: `irq_wake` high at a clock edge clears bits 1 and 0 at that edge and leaves bits 7, 3 and 2 unchanged. If a write lands in the same cycle, the wake still clears bits 1 and 0, and the write sets the other bits.
- R7: `baud_double` follows bit 7, and `gp_flag[1:0]` follows bits 3 and 2.
- R8: The clock enables change only at an edge that carries a register write or a wake. Reads and idle bus cycles leave them unchanged.
- R9: A write changes the enables only after the clock edge that captures it, never in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock |
| rst_n | input | 1 | Active-low reset |
| sfr_addr | input | 8 | SFR bus address |
| sfr_wr_en | input | 1 | SFR byte write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rd_data | output | 8 | Register value when addressed, else 0 |
| irq_wake | input | 1 | Interrupt wake request |
| cpu_clk_en | output | 1 | CPU core clock enable |
| osc_clk_en | output | 1 | Oscillator / peripheral clock enable |
| pwr_mode | output | 2 | 0 run, 1 light sleep, 2 deep sleep |
| baud_double | output | 1 | Serial baud-doubling flag |
| gp_flag | output | 2 | General-purpose flags |

## Verification
The bench builds the block with its default parameters: an 8-bit address and the register at 0x87. With these values every one of the 256 byte values can be written, read back and then woken from. Each value is checked against a byte model computed in the bench. Foreign writes are swept over all 255 other addresses. The bench also covers a write and a wake landing in the same cycle.

// File: rtl/pwr_ctrl_pkg.sv
package pwr_ctrl_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_IDLE  = 0;
  localparam int BIT_PDOWN = 1;
  localparam int BIT_GF0   = 2;
  localparam int BIT_GF1   = 3;
  localparam int BIT_BAUD  = 7;
  // bits that hold state; the rest read as zero
  localparam logic [REG_W-1:0] STORE_MASK = 8'b1000_1111;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_LIGHT = 2'd1,
    MODE_DEEP  = 2'd2
  } pwr_mode_e;
endpackage

// File: rtl/pwr_ctrl_reg.sv
module pwr_ctrl_reg
  import pwr_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wdata,
  input  logic             wake,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] d_next;

  always_comb begin
    d_next = q;
    if (wr_hit) d_next = wdata;
    if (wake) begin
      d_next[BIT_IDLE]  = 1'b0;
      d_next[BIT_PDOWN] = 1'b0;
    end
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (STORE_MASK[i]) begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[i] <= 1'b0;
        else        q[i] <= d_next[i];
      end
    end else begin : g_rsvd
      assign q[i] = 1'b0;
    end
  end

  AST_WAKE_CLEARS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (q[BIT_IDLE] == 1'b0 && q[BIT_PDOWN] == 1'b0)); // R6
  AST_WAKE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !wr_hit) |=> $stable({q[BIT_BAUD], q[BIT_GF1], q[BIT_GF0]})); // R6
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake && !wr_hit) |=> $stable(q)); // R8
endmodule

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
  import pwr_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      light_req,
  input  logic      deep_req,
  output pwr_mode_e mode,
  output logic      cpu_en,
  output logic      osc_en
);
  always_comb begin
    if (deep_req)       mode = MODE_DEEP;
    else if (light_req) mode = MODE_LIGHT;
    else                mode = MODE_RUN;
  end

  assign cpu_en = (mode == MODE_RUN);
  assign osc_en = (mode != MODE_DEEP);

  AST_OSC_OFF_CPU_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !cpu_en); // R5
  AST_DEEP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    deep_req |-> (!osc_en && mode == MODE_DEEP)); // R5
  AST_LIGHT_KEEPS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    (light_req && !deep_req) |-> (osc_en && !cpu_en)); // R4
endmodule

// File: rtl/pwr_sfr_port.sv
module pwr_sfr_port
  import pwr_ctrl_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  reg_q,
  output logic              wr_hit,
  output logic [REG_W-1:0]  rd_data
);
  logic sel;
  assign sel     = (addr == REG_ADDR);
  assign wr_hit  = sel && wr_en;
  assign rd_data = sel ? reg_q : '0;

  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != REG_ADDR) |-> (rd_data == '0)); // R2
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pwr_ctrl_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr_en,
  input  logic [REG_W-1:0]  sfr_wdata,
  output logic [REG_W-1:0]  sfr_rd_data,
  input  logic              irq_wake,
  output logic              cpu_clk_en,
  output logic              osc_clk_en,
  output logic [1:0]        pwr_mode,
  output logic              baud_double,
  output logic [1:0]        gp_flag
);
  logic             wr_hit;
  logic [REG_W-1:0] reg_q;
  pwr_mode_e        mode;

  pwr_sfr_port #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_port (
    .clk(clk), .rst_n(rst_n), .addr(sfr_addr), .wr_en(sfr_wr_en),
    .reg_q(reg_q), .wr_hit(wr_hit), .rd_data(sfr_rd_data)
  );

  pwr_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(sfr_wdata),
    .wake(irq_wake), .q(reg_q)
  );

  pwr_mode_decode u_dec (
    .clk(clk), .rst_n(rst_n), .light_req(reg_q[BIT_IDLE]),
    .deep_req(reg_q[BIT_PDOWN]), .mode(mode),
    .cpu_en(cpu_clk_en), .osc_en(osc_clk_en)
  );

  assign pwr_mode    = mode;
  assign baud_double = reg_q[BIT_BAUD];
  assign gp_flag     = {reg_q[BIT_GF1], reg_q[BIT_GF0]};

  AST_ENABLES_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !irq_wake) |=> ($stable(cpu_clk_en) && $stable(osc_clk_en))); // R8
  AST_WAKE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wake |=> (cpu_clk_en && osc_clk_en)); // R6
endmodule

// File: tb/pwr_clk_ctrl_tb_top.sv
module pwr_clk_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic       sfr_wr_en = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rd_data;
  logic       irq_wake = 1'b0;
  logic       cpu_clk_en, osc_clk_en, baud_double;
  logic [1:0] pwr_mode, gp_flag;

  int checks = 0;
  int errors = 0;
  logic [7:0] model = 8'h00;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_clk_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr_en(sfr_wr_en),
    .sfr_wdata(sfr_wdata), .sfr_rd_data(sfr_rd_data), .irq_wake(irq_wake),
    .cpu_clk_en(cpu_clk_en), .osc_clk_en(osc_clk_en), .pwr_mode(pwr_mode),
    .baud_double(baud_double), .gp_flag(gp_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive at negedge, capture at posedge, return at next negedge
  task automatic bus_cycle(input logic [7:0] a, input logic we, input logic [7:0] d, input logic wk);
    sfr_addr = a; sfr_wr_en = we; sfr_wdata = d; irq_wake = wk;
    @(negedge clk);
    sfr_wr_en = 1'b0; irq_wake = 1'b0;
  endtask

  task automatic check_outputs(input string req);
    int em;
    em = model[1] ? 2 : (model[0] ? 1 : 0);
    sfr_addr = 8'h87; #0.5;
    chk({req, " rd"}, sfr_rd_data, model);
    chk({req, " cpu_en R4"}, cpu_clk_en, !(model[0] | model[1]));
    chk({req, " osc_en R5"}, osc_clk_en, !model[1]);
    chk({req, " mode R5"}, pwr_mode, em);
    chk({req, " baud R7"}, baud_double, model[7]);
    chk({req, " gp R7"}, gp_flag, model[3:2]);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check_outputs("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1 after release");

    // R2 R3 R4 R5 R7 R8 R6: sweep every byte value
    for (int v = 0; v < 256; v++) begin
      bus_cycle(8'h87, 1'b1, v[7:0], 1'b0);
      model = v[7:0] & 8'h8F;
      check_outputs("R2/R3 write");
      // R2 read miss
      sfr_addr = 8'h86; #0.5;
      chk("R2 miss read", sfr_rd_data, 0);
      // R8 idle cycle with a read
      bus_cycle(8'h87, 1'b0, 8'hFF, 1'b0);
      chk("R8 cpu_en steady", cpu_clk_en, !(model[0] | model[1]));
      chk("R8 osc_en steady", osc_clk_en, !model[1]);
      // R6 wake
      bus_cycle(8'h00, 1'b0, 8'h00, 1'b1);
      model = model & 8'hFC;
      check_outputs("R6 wake");
    end

    // R2 foreign writes leave register unchanged
    bus_cycle(8'h87, 1'b1, 8'h8E, 1'b0);
    model = 8'h8E;
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h87) begin
        bus_cycle(a[7:0], 1'b1, 8'h01, 1'b0);
        sfr_addr = 8'h87; #0.5;
        chk("R2 foreign write", sfr_rd_data, model);
      end
    end
    check_outputs("R2 after foreign");

    // R6 write and wake in the same cycle
    bus_cycle(8'h87, 1'b1, 8'h8F, 1'b1);
    model = 8'h8C;
    check_outputs("R6 write+wake");
    bus_cycle(8'h87, 1'b1, 8'h03, 1'b1);
    model = 8'h00;
    check_outputs("R6 write+wake clear");

    // R9 enables change only after the capturing edge
    sfr_addr = 8'h87; sfr_wr_en = 1'b1; sfr_wdata = 8'h02;
    #1;
    chk("R9 before edge cpu_en", cpu_clk_en, 1);
    chk("R9 before edge osc_en", osc_clk_en, 1);
    @(negedge clk);
    sfr_wr_en = 1'b0;
    chk("R9 after edge osc_en", osc_clk_en, 0);
    chk("R9 after edge cpu_en", cpu_clk_en, 0);
    model = 8'h02;
    // R5 deep sleep then wake back to run
    bus_cycle(8'h87, 1'b0, 8'h00, 1'b1);
    model = 8'h00;
    check_outputs("R6 wake from deep");

    // R1 reset clears flags
    bus_cycle(8'h87, 1'b1, 8'h8D, 1'b0);
    rst_n = 1'b0; #1;
    model = 8'h00;
    check_outputs("R1 reset again");
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule